// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates motor winding current by chopping the bridge. It watches a single, already synchronized flag that is high whenever the measured sense voltage is above the current reference. While the bridge is conducting, a high flag ends the conduction interval and starts a fixed off interval. The flag is only accepted once two windows have both elapsed. The first is a leading-edge blanking window that hides the reverse-recovery spike after turn-on. The second is a minimum conduction time.

The off interval runs a four-step slow-decay sequence. First the low-side switch opens and current freewheels through the high side. After a dead time, the high-side switch conducts as a synchronous rectifier. When the off-time monostable expires, that switch opens again. After a second dead time, the bridge returns to conduction. The effective off time is therefore the monostable time plus one dead time.

The bridge gate logic reads a two-bit phase code from the block. A one-cycle strobe marks each entry into the off sequence. All window lengths are parameters counted in clock cycles, so the off time can span from a few microseconds to milliseconds. The interface consists only of plain control and status pins and carries no data stream, so no valid/ready handshake is involved.

Top module: `chop_offtime`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `phase` reads 2'b00 (conduct) and `off_strobe` is low.
- R2: The conduct phase ends after a clock edge at which `enable` is high, `sense_hi` is high and both windows have elapsed. From the next cycle `phase` reads 2'b01 (first dead time), and `off_strobe` is high in that same cycle.
- R3: During the first BLANK_CYC cycles of every conduct phase, `sense_hi` is ignored and leaves no trace: a flag that is high only inside the window does not end the phase.
- R4: A conduct phase lasts at least MIN_ON_CYC cycles, even when `sense_hi` is held high throughout. With `sense_hi` held high, the phase lasts max(BLANK_CYC+1, MIN_ON_CYC) cycles.
- R5: The first dead time (2'b01) lasts DEAD_CYC cycles and is always followed by synchronous rectification (2'b10).
- R6: Synchronous rectification lasts OFF_CYC−DEAD_CYC cycles, so the monostable spans OFF_CYC cycles from the first dead-time cycle. The second dead time (2'b11) then lasts DEAD_CYC cycles before conduct resumes, giving OFF_CYC+DEAD_CYC off cycles in total.
- R7: Changes on `sense_hi` during the off sequence have no effect on the length of any step.
- R8: When `enable` is low, `phase` reads 2'b00 from the next cycle and `off_strobe` stays low, whatever `sense_hi` does. When `enable` rises again, both windows restart from zero.
- R9: `off_strobe` is high for exactly one cycle per off sequence, and never in any other cycle.
- R10: Each return to conduct after the second dead time restarts the blanking and minimum-on windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Bridge enable; low forces the conduct state |
| sense_hi | input | 1 | Synchronized flag, high when sense exceeds the reference |
| phase | output | 2 | 00 conduct, 01 first dead time, 10 synchronous rectification, 11 second dead time |
| off_strobe | output | 1 | One-cycle pulse on the first cycle of each off sequence |

## Verification
A wrong window counter appears as a conduct phase that is too short or too long, measured from enable or from the end of the second dead time. It is visible at `phase` within the first cycle in which the flag is accepted. A wrong off-timer count or a wrong step order shows on the next `phase` change inside the off sequence, so the fault appears within OFF_CYC+DEAD_CYC cycles of the strobe. A blanking window that latches instead of gating is exposed when a spike confined to the window is later followed by an early exit from conduct. A stale step after a disable shows one cycle after `enable` falls.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    PH_ON  = 2'b00,
    PH_DT1 = 2'b01,
    PH_SR  = 2'b10,
    PH_DT2 = 2'b11
  } phase_e;
endpackage

// File: rtl/chop_on_gate.sv
// Counts cycles of the conduct phase and reports when the sense flag may be accepted.
module chop_on_gate #(
  parameter int BLANK_CYC  = 200,
  parameter int MIN_ON_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic accept
);
  localparam int MINIDX = (MIN_ON_CYC > 0) ? MIN_ON_CYC - 1 : 0;
  localparam int LIM    = (BLANK_CYC > MINIDX) ? BLANK_CYC : MINIDX;
  localparam int W      = $clog2(LIM + 2);
  localparam logic [W-1:0] BLANK_V = W'(BLANK_CYC);
  localparam logic [W-1:0] MINI_V  = W'(MINIDX);
  localparam logic [W-1:0] LIM_V   = W'(LIM);

  logic [W-1:0] idx_q;
  logic         blank_over;
  logic         min_over;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) idx_q <= '0;
    else if (idx_q != LIM_V) idx_q <= idx_q + 1'b1;
  end

  assign blank_over = (idx_q >= BLANK_V);
  assign min_over   = (idx_q >= MINI_V);
  assign accept     = blank_over && min_over;

  // R10: the index never runs past its saturation value
  a_r10_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LIM_V);
  // R3: after a restart the index always begins from zero
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx_q == '0));
endmodule

// File: rtl/chop_off_timer.sv
// Counts cycles of the off sequence; flags the end of each step.
module chop_off_timer #(
  parameter int DEAD_CYC = 200,
  parameter int OFF_CYC  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic busy,
  output logic dt1_end,
  output logic mono_end,
  output logic dt2_end
);
  localparam int TOT = OFF_CYC + DEAD_CYC;
  localparam int W   = $clog2(TOT + 2);
  localparam logic [W-1:0] DEAD_V = W'(DEAD_CYC);
  localparam logic [W-1:0] OFF_V  = W'(OFF_CYC);
  localparam logic [W-1:0] TOT_V  = W'(TOT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)      cnt_q <= '0;
    else if (start)             cnt_q <= W'(1);
    else if (busy && !dt2_end)  cnt_q <= cnt_q + 1'b1;
    else                        cnt_q <= '0;
  end

  assign dt1_end  = busy && (cnt_q == DEAD_V);
  assign mono_end = busy && (cnt_q == OFF_V);
  assign dt2_end  = busy && (cnt_q == TOT_V);

  // R6: the count never passes the full off length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOT_V);
  // R6: each start begins the count at one
  a_r6_start_one: assert property (@(posedge clk) disable iff (!rst_n)
    (start && enable) |=> (cnt_q == W'(1)));
endmodule

// File: rtl/chop_seq.sv
// Four-step slow-decay sequencer.
module chop_seq (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            sense_hi,
  input  logic            accept,
  input  logic            dt1_end,
  input  logic            mono_end,
  input  logic            dt2_end,
  output chop_pkg::phase_e phase,
  output logic            trip,
  output logic            strobe
);
  import chop_pkg::*;

  phase_e ph_q, ph_d;
  logic   strobe_q;

  assign trip = (ph_q == PH_ON) && enable && accept && sense_hi;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_ON:  if (trip)     ph_d = PH_DT1;
      PH_DT1: if (dt1_end)  ph_d = PH_SR;
      PH_SR:  if (mono_end) ph_d = PH_DT2;
      PH_DT2: if (dt2_end)  ph_d = PH_ON;
      default:              ph_d = PH_ON;
    endcase
    if (!enable) ph_d = PH_ON;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_ON;
      strobe_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      strobe_q <= trip;
    end
  end

  assign phase  = ph_q;
  assign strobe = strobe_q;

  // R5: steps only advance in their fixed order
  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |->
      ((ph_q == PH_ON) ||
       (ph_q == PH_DT1 && $past(ph_q) == PH_ON) ||
       (ph_q == PH_SR  && $past(ph_q) == PH_DT1) ||
       (ph_q == PH_DT2 && $past(ph_q) == PH_SR)));
  // R8: disable forces conduct in the next cycle
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ph_q == PH_ON && !strobe_q));
  // R9: the strobe is never two cycles long
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  // R2: strobe coincides with the first dead-time cycle entered from conduct
  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (ph_q == PH_DT1 && $past(ph_q) == PH_ON && $past(sense_hi)));
  // R7: while enabled the early off steps cannot fall back to conduct
  a_r7_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_DT1 || ph_q == PH_SR) && enable) |=> (ph_q != PH_ON));
endmodule

// File: rtl/chop_offtime.sv
module chop_offtime #(
  parameter int BLANK_CYC  = 200,
  parameter int MIN_ON_CYC = 500,
  parameter int DEAD_CYC   = 200,
  parameter int OFF_CYC    = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sense_hi,
  output logic [1:0] phase,
  output logic       off_strobe
);
  import chop_pkg::*;

  localparam int MINIDX = (MIN_ON_CYC > 0) ? MIN_ON_CYC - 1 : 0;
  localparam int LIM    = (BLANK_CYC > MINIDX) ? BLANK_CYC : MINIDX;
  localparam int RW     = $clog2(LIM + 2);
  localparam logic [RW-1:0] LIM_V = RW'(LIM);

  phase_e ph;
  logic   accept, trip, strobe;
  logic   dt1_end, mono_end, dt2_end;
  logic   on_restart;

  assign on_restart = !enable || (ph != PH_ON);

  chop_on_gate #(.BLANK_CYC(BLANK_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .restart(on_restart), .accept(accept)
  );

  chop_off_timer #(.DEAD_CYC(DEAD_CYC), .OFF_CYC(OFF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(trip),
    .busy(ph != PH_ON), .dt1_end(dt1_end), .mono_end(mono_end), .dt2_end(dt2_end)
  );

  chop_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sense_hi(sense_hi),
    .accept(accept), .dt1_end(dt1_end), .mono_end(mono_end), .dt2_end(dt2_end),
    .phase(ph), .trip(trip), .strobe(strobe)
  );

  assign phase      = ph;
  assign off_strobe = strobe;

  // Independent count of enabled conduct cycles, used to check the windows.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !enable || ph != PH_ON) run_q <= '0;
    else if (run_q != LIM_V)              run_q <= run_q + 1'b1;
  end

  // R4: conduct is only left once both windows have run out
  a_r4_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DT1 && $past(ph) == PH_ON) |-> ($past(run_q) == LIM_V));
endmodule

// File: tb/chop_offtime_test.sv
module chop_offtime_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sense_hi = 1'b0;
  logic [1:0] phase, phase_b;
  logic off_strobe, off_strobe_b;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] P_ON = 2'b00, P_DT1 = 2'b01, P_SR = 2'b10, P_DT2 = 2'b11;

  always #2.5 clk = ~clk;

  // Min-on binding: conduct with sense high lasts 10 cycles.
  chop_offtime #(.BLANK_CYC(4), .MIN_ON_CYC(10), .DEAD_CYC(3), .OFF_CYC(12)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sense_hi(sense_hi),
    .phase(phase), .off_strobe(off_strobe)
  );
  // Blanking binding: conduct with sense high lasts 8 cycles.
  chop_offtime #(.BLANK_CYC(7), .MIN_ON_CYC(3), .DEAD_CYC(3), .OFF_CYC(12)) uut_b (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sense_hi(sense_hi),
    .phase(phase_b), .off_strobe(off_strobe_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic restart();
    enable = 1'b0;
    tick();
    tick();
    enable = 1'b1;
  endtask

  // Counts consecutive samples of uut in phase ph, starting with the current one.
  task automatic span(input logic [1:0] ph, output int n, output int strobes);
    n = 0;
    strobes = 0;
    for (int i = 0; i < 1000 && phase == ph; i++) begin
      n++;
      if (off_strobe) strobes++;
      tick();
    end
  endtask

  task automatic t_reset();
    tick();
    chk(phase == P_ON && phase_b == P_ON, "R1 phase in reset", int'(phase), 0);
    chk(!off_strobe && !off_strobe_b, "R1 strobe in reset", int'(off_strobe), 0);
    rst_n = 1'b1;
    tick();
    chk(phase == P_ON && !off_strobe, "R1 first cycle after reset", int'(phase), 0);
  endtask

  task automatic t_windows();
    int na, nb;
    na = 0;
    nb = 0;
    sense_hi = 1'b1;
    restart();
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (na == 0 && phase == P_DT1) begin
        na = k;
        chk(off_strobe == 1'b1, "R2 strobe on off entry", int'(off_strobe), 1);
      end
      if (nb == 0 && phase_b == P_DT1) nb = k;
      if (na != 0 && nb != 0) break;
    end
    chk(na == 10, "R4 min-on length", na, 10);
    chk(nb == 8, "R3 blanking length", nb, 8);
  endtask

  task automatic t_sequence();
    int n, s;
    sense_hi = 1'b1;
    restart();
    while (phase != P_DT1) tick();
    span(P_DT1, n, s);
    chk(n == 3, "R5 first dead time length", n, 3);
    chk(s == 1, "R9 one strobe per off sequence", s, 1);
    chk(phase == P_SR, "R5 rectification follows dead time", int'(phase), int'(P_SR));
    span(P_SR, n, s);
    chk(n == 9, "R6 rectification length", n, 9);
    span(P_DT2, n, s);
    chk(n == 3, "R6 second dead time length", n, 3);
    chk(s == 0, "R9 no strobe inside off sequence", s, 0);
    span(P_ON, n, s);
    chk(n == 10, "R10 windows restart after off", n, 10);
    // R7: toggle the sense flag throughout the next off sequence
    n = 0;
    for (int i = 0; i < 100 && phase != P_ON; i++) begin
      n++;
      sense_hi = ~sense_hi;
      tick();
    end
    chk(n == 15, "R7 off length with toggling sense", n, 15);
    sense_hi = 1'b0;
  endtask

  task automatic t_blank_spike();
    sense_hi = 1'b1;
    restart();
    repeat (4) tick();
    sense_hi = 1'b0;
    repeat (25) tick();
    chk(phase == P_ON, "R3 spike inside blanking ignored", int'(phase), 0);
    sense_hi = 1'b1;
    tick();
    chk(phase == P_DT1 && off_strobe, "R2 late trip after one cycle", int'(phase), 1);
    sense_hi = 1'b0;
    restart();
    sense_hi = 1'b1;
    repeat (9) tick();
    sense_hi = 1'b0;
    repeat (20) tick();
    chk(phase == P_ON, "R4 flag inside min-on not remembered", int'(phase), 0);
  endtask

  task automatic t_disable();
    int n;
    sense_hi = 1'b1;
    restart();
    while (phase != P_SR) tick();
    enable = 1'b0;
    tick();
    chk(phase == P_ON && !off_strobe, "R8 disable forces conduct", int'(phase), 0);
    repeat (6) tick();
    chk(phase == P_ON && !off_strobe, "R8 held in conduct while disabled", int'(phase), 0);
    enable = 1'b1;
    n = 0;
    for (int i = 0; i < 50 && phase == P_ON; i++) begin
      n++;
      tick();
    end
    chk(n == 10, "R8 windows restart on re-enable", n, 10);
    sense_hi = 1'b0;
  endtask

  initial begin
    t_reset();
    t_windows();
    t_sequence();
    t_blank_spike();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule